// File: doc/BRIEF.md
# Host I/O to RAM Window Mapper

This block sits between a host I/O port decoder and an on-chip shared RAM. It compares each host I/O address with two programmable windows. When an address falls inside an enabled window, the host read or write is turned into a RAM access. Each window has a base address, a power-of-two size and its own read and write protection. Protection can cover the lower half, the upper half or the whole window, and read and write protection are set apart from each other.

A protected access never reaches the RAM. A protected read returns FFh to the host and a protected write is dropped. Either kind raises a violation pulse. All RAM-side outputs are registered, so they appear one clock after the host strobe. The read data going back to the host is formed from the RAM data in that same output cycle. A typical use is a read/write mailbox window next to a read-only status window, for example a window at 900h that the host can read but not write.

Top module: `hio_ram_window`

## Requirements
- R1: When `cfg_map_en` is 0, no host strobe produces `ram_rd`, `ram_wr`, `viol` or `host_rvalid`.
- R2: Window w takes part in decoding only when `cfg_win_en[w]` is 1; with it at 0, an address inside that window produces no access.
- R3: Size code n in `cfg_size` (3 bits per window, window w at bits [3w+2:3w]) gives a window of 16<<n bytes, from 16 to 2048. The address base+size-1 hits and base+size misses.
- R4: `cfg_base` (12 bits per window, window w at bits [12w+11:12w]) is in 16-byte units. A value of 80h starts the window at I/O address 800h, so 7FFh misses and 800h hits.
- R5: The 2-bit read-protect field of a window (`cfg_rprot`, window w at bits [2w+1:2w]) is decoded as 00 none, 01 lower half, 10 upper half, 11 whole window. The upper half is offsets from size/2 to size-1.
- R6: The 2-bit write-protect field (`cfg_wprot`, same layout and encodings) acts independently of read protection. If both strobes are high in one cycle, the cycle is a read and the write is ignored.
- R7: A protected read gives no `ram_rd`. It gives `host_rvalid` with `host_rdata` = FFh, and `viol` high for that one cycle.
- R8: A protected write gives no `ram_wr`, so the RAM location is unchanged, and it raises `viol` for one cycle.
- R9: When both windows contain the address, window 0 decides the mapping and the protection.
- R10: A permitted access drives `ram_rd` or `ram_wr` one cycle after the strobe. `ram_addr` is the window base in bytes plus the offset inside the window, taken to RAM_AW bits. `ram_wdata` is the host data, and `host_rdata` is the RAM data.
- R11: While reset is held, and after it until the first strobe, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| cfg_map_en | input | 1 | Global enable for mapping host I/O cycles to RAM |
| cfg_win_en | input | NWIN | Per-window enable |
| cfg_base | input | NWIN*12 | Per-window base address in 16-byte units |
| cfg_size | input | NWIN*3 | Per-window size code (16<<n bytes) |
| cfg_rprot | input | NWIN*2 | Per-window read-protect field |
| cfg_wprot | input | NWIN*2 | Per-window write-protect field |
| io_addr | input | HA_W | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | DW | Host write data |
| ram_rdata | input | DW | Read data from the RAM for the current `ram_addr` |
| ram_addr | output | RAM_AW | RAM address |
| ram_rd | output | 1 | RAM read enable |
| ram_wr | output | 1 | RAM write enable |
| ram_wdata | output | DW | RAM write data |
| host_rvalid | output | 1 | A host read that hit a window completes this cycle |
| host_rdata | output | DW | Data returned to the host (FFh when protected) |
| viol | output | 1 | Protection violation pulse |

## Verification
Every RAM-side output and `viol` is due exactly one rising edge after the edge that samples the host strobe. `host_rdata` follows combinationally from the RAM data in that same cycle. The bench changes inputs on the falling edge, computes the expected result from its own behavioural window model and RAM shadow, and compares just after the next rising edge. It does this on every cycle, idle cycles included, so that a missing or lingering one-cycle pulse is caught. After reset is released, the bench waits out the two synchronizer cycles before it applies the first strobe.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

  localparam int SZ_W = 3;
  localparam int PR_W = 2;

  typedef enum logic [PR_W-1:0] {
    PROT_NONE = 2'b00,
    PROT_LOW  = 2'b01,
    PROT_HIGH = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  // Returns 1 when the given protection setting covers the half the offset lies in.
  function automatic logic prot_covers(prot_e p, logic upper);
    case (p)
      PROT_NONE: prot_covers = 1'b0;
      PROT_LOW:  prot_covers = ~upper;
      PROT_HIGH: prot_covers = upper;
      default:   prot_covers = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/hrw_rst_sync.sv
module hrw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/hrw_win_decode.sv
module hrw_win_decode
  import hrw_pkg::*;
#(
  parameter int HA_W   = 16,
  parameter int RAM_AW = 12,
  localparam int BASE_W = HA_W - 4
) (
  input  logic              en,
  input  logic [HA_W-1:0]   addr,
  input  logic [BASE_W-1:0] base,
  input  logic [SZ_W-1:0]   size_code,
  input  logic [PR_W-1:0]   rprot,
  input  logic [PR_W-1:0]   wprot,
  output logic              hit,
  output logic              rd_blk,
  output logic              wr_blk,
  output logic [RAM_AW-1:0] ram_a
);
  logic [HA_W-1:0] start;
  logic [HA_W-1:0] size_b;
  logic [HA_W:0]   diff;
  logic            upper;

  always_comb begin
    start  = {base, 4'b0000};
    size_b = {{(HA_W-5){1'b0}}, 5'd16} << size_code;
    diff   = {1'b0, addr} - {1'b0, start};
    hit    = en & ~diff[HA_W] & (diff[HA_W-1:0] < size_b);
    upper  = |(diff[HA_W-1:0] & (size_b >> 1));
    rd_blk = prot_covers(prot_e'(rprot), upper);
    wr_blk = prot_covers(prot_e'(wprot), upper);
    ram_a  = start[RAM_AW-1:0] + diff[RAM_AW-1:0];
  end
endmodule

// File: rtl/hrw_prio_sel.sv
module hrw_prio_sel #(
  parameter int NWIN = 2
) (
  input  logic [NWIN-1:0] hits,
  output logic [NWIN-1:0] sel,
  output logic            any
);
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      if (hits[w] && !any) begin
        sel[w] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hio_ram_window.sv
module hio_ram_window
  import hrw_pkg::*;
#(
  parameter int NWIN   = 2,
  parameter int HA_W   = 16,
  parameter int RAM_AW = 12,
  parameter int DW     = 8,
  localparam int BASE_W = HA_W - 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_map_en,
  input  logic [NWIN-1:0]        cfg_win_en,
  input  logic [NWIN*BASE_W-1:0] cfg_base,
  input  logic [NWIN*SZ_W-1:0]   cfg_size,
  input  logic [NWIN*PR_W-1:0]   cfg_rprot,
  input  logic [NWIN*PR_W-1:0]   cfg_wprot,
  input  logic [HA_W-1:0]        io_addr,
  input  logic                   io_rd,
  input  logic                   io_wr,
  input  logic [DW-1:0]          io_wdata,
  input  logic [DW-1:0]          ram_rdata,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic                   ram_rd,
  output logic                   ram_wr,
  output logic [DW-1:0]          ram_wdata,
  output logic                   host_rvalid,
  output logic [DW-1:0]          host_rdata,
  output logic                   viol
);
  logic rst_sync_n;

  hrw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  logic [NWIN-1:0]   hits, rblk, wblk, sel;
  logic [RAM_AW-1:0] wa [NWIN];
  logic              any_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    hrw_win_decode #(.HA_W(HA_W), .RAM_AW(RAM_AW)) u_dec (
      .en        (cfg_map_en & cfg_win_en[w]),
      .addr      (io_addr),
      .base      (cfg_base[w*BASE_W +: BASE_W]),
      .size_code (cfg_size[w*SZ_W +: SZ_W]),
      .rprot     (cfg_rprot[w*PR_W +: PR_W]),
      .wprot     (cfg_wprot[w*PR_W +: PR_W]),
      .hit       (hits[w]),
      .rd_blk    (rblk[w]),
      .wr_blk    (wblk[w]),
      .ram_a     (wa[w])
    );
  end

  hrw_prio_sel #(.NWIN(NWIN)) u_sel (.hits(hits), .sel(sel), .any(any_hit));

  // Next-state logic
  logic              rd_blk_s, wr_blk_s, is_rd, is_wr, acc_en;
  logic [RAM_AW-1:0] addr_s;
  logic              rd_d, wr_d, viol_d, rvalid_d, blk_d;

  always_comb begin
    rd_blk_s = 1'b0;
    wr_blk_s = 1'b0;
    addr_s   = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel[w]) begin
        rd_blk_s = rd_blk_s | rblk[w];
        wr_blk_s = wr_blk_s | wblk[w];
        addr_s   = addr_s | wa[w];
      end
    end
    is_rd    = any_hit & io_rd;
    is_wr    = any_hit & io_wr & ~io_rd;
    rd_d     = is_rd & ~rd_blk_s;
    wr_d     = is_wr & ~wr_blk_s;
    viol_d   = (is_rd & rd_blk_s) | (is_wr & wr_blk_s);
    rvalid_d = is_rd;
    blk_d    = is_rd & rd_blk_s;
    acc_en   = is_rd | is_wr;
  end

  // Registers
  logic blk_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ram_rd      <= 1'b0;
      ram_wr      <= 1'b0;
      viol        <= 1'b0;
      host_rvalid <= 1'b0;
      blk_q       <= 1'b0;
    end else begin
      ram_rd      <= rd_d;
      ram_wr      <= wr_d;
      viol        <= viol_d;
      host_rvalid <= rvalid_d;
      blk_q       <= blk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else if (acc_en) begin
      ram_addr  <= addr_s;
      ram_wdata <= io_wdata;
    end
  end

  assign host_rdata = !host_rvalid ? '0 : (blk_q ? {DW{1'b1}} : ram_rdata);

endmodule

// File: rtl/hrw_checker.sv
module hrw_checker #(
  parameter int RAM_AW = 12,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_map_en,
  input logic [RAM_AW-1:0] io_addr_lo,
  input logic              io_rd,
  input logic              io_wr,
  input logic [DW-1:0]     io_wdata,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_rd,
  input logic              ram_wr,
  input logic [DW-1:0]     ram_wdata,
  input logic              host_rvalid,
  input logic [DW-1:0]     host_rdata,
  input logic              viol
);
  AST_OFF_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_map_en |=> !ram_rd && !ram_wr && !viol && !host_rvalid); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd && !io_wr |=> !ram_rd && !ram_wr && !viol && !host_rvalid); // R7

  AST_VIOL_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !ram_rd && !ram_wr); // R8

  AST_BLOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid && !ram_rd |-> host_rdata == {DW{1'b1}} && viol); // R7

  AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |=> (!ram_rd && !ram_wr) || ram_addr == $past(io_addr_lo)); // R10

  AST_WDATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> !ram_wr || ram_wdata == $past(io_wdata)); // R10

  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> !ram_wr); // R6
endmodule

bind hio_ram_window hrw_checker #(.RAM_AW(RAM_AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_map_en  (cfg_map_en),
  .io_addr_lo  (io_addr[RAM_AW-1:0]),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_wdata    (io_wdata),
  .ram_addr    (ram_addr),
  .ram_rd      (ram_rd),
  .ram_wr      (ram_wr),
  .ram_wdata   (ram_wdata),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata),
  .viol        (viol)
);

// File: tb/sim_hio_ram_window.sv
`timescale 1ns/1ps
module sim_hio_ram_window;
  localparam int NWIN = 2, HA_W = 16, RAM_AW = 12, DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_map_en;
  logic [NWIN-1:0] cfg_win_en;
  logic [NWIN*12-1:0] cfg_base;
  logic [NWIN*3-1:0] cfg_size;
  logic [NWIN*2-1:0] cfg_rprot, cfg_wprot;
  logic [HA_W-1:0] io_addr;
  logic io_rd, io_wr;
  logic [DW-1:0] io_wdata, ram_rdata, ram_wdata, host_rdata;
  logic [RAM_AW-1:0] ram_addr;
  logic ram_rd, ram_wr, host_rvalid, viol;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] ref_mem [0:4095];

  always #2 clk = ~clk;

  hio_ram_window #(.NWIN(NWIN), .HA_W(HA_W), .RAM_AW(RAM_AW), .DW(DW)) u0 (.*);

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_wr) mem[ram_addr] <= ram_wdata;

  // Behavioural reference of one host cycle
  task automatic model(input bit rd, input bit wr, input int addr,
                       output bit e_rd, output bit e_wr, output bit e_v,
                       output bit e_rv, output int e_addr, output bit e_blk);
    int found = -1, off = 0, start, sz, rp, wp;
    bit up, rb, wb;
    e_rd = 0; e_wr = 0; e_v = 0; e_rv = 0; e_addr = 0; e_blk = 0;
    for (int w = 0; w < NWIN; w++) begin
      start = int'(cfg_base[w*12 +: 12]) * 16;
      sz    = 16 << cfg_size[w*3 +: 3];
      if (found < 0 && cfg_map_en && cfg_win_en[w] && addr >= start && addr < start + sz) begin
        found = w; off = addr - start;
      end
    end
    if (found < 0 || !(rd || wr)) return;
    sz = 16 << cfg_size[found*3 +: 3];
    up = off >= sz / 2;
    rp = int'(cfg_rprot[found*2 +: 2]);
    wp = int'(cfg_wprot[found*2 +: 2]);
    rb = (rp == 3) || (rp == 1 && !up) || (rp == 2 && up);
    wb = (wp == 3) || (wp == 1 && !up) || (wp == 2 && up);
    e_addr = addr % 4096;
    if (rd) begin
      e_rv = 1; e_blk = rb; e_rd = !rb; e_v = rb;
    end else begin
      e_wr = !wb; e_v = wb;
    end
  endtask

  task automatic step(input bit rd, input bit wr, input int addr, input logic [7:0] wd,
                      input string tag);
    bit e_rd, e_wr, e_v, e_rv, e_blk, bad;
    int e_addr;
    logic [7:0] e_data;
    io_rd = rd; io_wr = wr; io_addr = addr[15:0]; io_wdata = wd;
    model(rd, wr, addr, e_rd, e_wr, e_v, e_rv, e_addr, e_blk);
    e_data = e_blk ? 8'hFF : ref_mem[e_addr];
    @(posedge clk); #1;
    checks++;
    bad = {ram_rd, ram_wr, viol, host_rvalid} != {e_rd, e_wr, e_v, e_rv};
    if ((e_rd || e_wr) && ram_addr != e_addr[11:0]) bad = 1;
    if (e_wr && ram_wdata != wd) bad = 1;
    if (e_rv && host_rdata != e_data) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s addr=%h: act rd/wr/v/rv=%b%b%b%b a=%h wd=%h rdat=%h exp %b%b%b%b a=%h wd=%h rdat=%h",
               tag, addr[15:0], ram_rd, ram_wr, viol, host_rvalid, ram_addr, ram_wdata, host_rdata,
               e_rd, e_wr, e_v, e_rv, e_addr[11:0], wd, e_data);
    end
    if (e_wr) ref_mem[e_addr] = wd;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 8'h00, tag);
  endtask

  task automatic set_win(input int w, input bit en, input int base, input int sz,
                         input int rp, input int wp);
    cfg_win_en[w] = en;
    cfg_base[w*12 +: 12] = base[11:0];
    cfg_size[w*3 +: 3] = sz[2:0];
    cfg_rprot[w*2 +: 2] = rp[1:0];
    cfg_wprot[w*2 +: 2] = wp[1:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i) ^ 8'h3C; ref_mem[i] = 8'(i) ^ 8'h3C;
    end
    rst_n = 0; cfg_map_en = 1; cfg_win_en = '0; cfg_base = '0; cfg_size = '0;
    cfg_rprot = '0; cfg_wprot = '0; io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
    set_win(0, 1, 'h80, 4, 0, 0);
    set_win(1, 1, 'h90, 4, 0, 3);
    io_rd = 1; io_addr = 16'h0800;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({ram_rd, ram_wr, viol, host_rvalid, ram_addr, ram_wdata} != '0) begin
      errors++;
      $display("FAIL R11 reset outputs act=%b%b%b%b exp=0000", ram_rd, ram_wr, viol, host_rvalid);
    end
    io_rd = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    idle("R11 idle after reset");

    // R10 basic mapping, write then read back
    step(0, 1, 'h805, 8'h5A, "R10 write");
    idle("R10 idle");
    step(1, 0, 'h805, 8'h00, "R10 read back");
    step(1, 0, 'h8FF, 8'h00, "R10 read last byte");

    // R4 base in 16-byte units
    step(1, 0, 'h7FF, 8'h00, "R4 below base");
    step(1, 0, 'h800, 8'h00, "R4 at base");

    // R1 global enable
    cfg_map_en = 0;
    step(1, 0, 'h810, 8'h00, "R1 read off");
    step(0, 1, 'h810, 8'h11, "R1 write off");
    cfg_map_en = 1;

    // R2 window enable
    cfg_win_en[0] = 0;
    step(1, 0, 'h820, 8'h00, "R2 win0 disabled");
    cfg_win_en[0] = 1;
    step(1, 0, 'h820, 8'h00, "R2 win0 enabled");

    // Read-only window at 900h
    step(0, 1, 'h900, 8'hA5, "R8 write to read-only window");
    idle("R8 viol one cycle");
    step(1, 0, 'h900, 8'h00, "R8 location unchanged");

    // R3 sizes, window 1 disabled
    cfg_win_en[1] = 0;
    for (int n = 0; n < 8; n++) begin
      set_win(0, 1, 'h10, n, 0, 0);
      step(0, 1, 'h100 + (16 << n) - 1, 8'(n + 8'h40), "R3 write last byte");
      step(1, 0, 'h100 + (16 << n) - 1, 8'h00, "R3 read last byte");
      step(1, 0, 'h100 + (16 << n), 8'h00, "R3 past end");
      step(1, 0, 'h0FF, 8'h00, "R3 before start");
    end

    // R5 read protection encodings on a 64-byte window
    for (int p = 0; p < 4; p++) begin
      set_win(0, 1, 'h20, 2, p, 0);
      step(1, 0, 'h203, 8'h00, "R5 lower half read");
      step(1, 0, 'h21F, 8'h00, "R5 last lower byte");
      step(1, 0, 'h220, 8'h00, "R5 first upper byte");
      step(1, 0, 'h23E, 8'h00, "R5 upper half read");
      idle("R7 viol cleared");
    end

    // R6 write protection, independent of read protection
    for (int p = 0; p < 4; p++) begin
      set_win(0, 1, 'h20, 2, 3 - p, p);
      step(0, 1, 'h204, 8'(8'h90 + p), "R6 lower write");
      step(0, 1, 'h230, 8'(8'hA0 + p), "R6 upper write");
      set_win(0, 1, 'h20, 2, 0, p);
      step(1, 0, 'h204, 8'h00, "R8 lower readback");
      step(1, 0, 'h230, 8'h00, "R8 upper readback");
    end
    set_win(0, 1, 'h20, 2, 0, 0);
    step(1, 1, 'h208, 8'hEE, "R6 both strobes is a read");
    step(1, 0, 'h208, 8'h00, "R6 write ignored");

    // R9 overlap, window 0 wins
    set_win(0, 1, 'h80, 1, 3, 3);
    set_win(1, 1, 'h80, 3, 0, 0);
    step(1, 0, 'h810, 8'h00, "R9 win0 protection wins");
    step(0, 1, 'h810, 8'h77, "R9 win0 write protection wins");
    step(1, 0, 'h850, 8'h00, "R9 win1 beyond win0");
    set_win(0, 1, 'h80, 1, 0, 0);
    set_win(1, 1, 'h80, 3, 3, 3);
    step(0, 1, 'h811, 8'h66, "R9 win0 unprotected write");
    step(1, 0, 'h811, 8'h00, "R9 readback");
    step(1, 0, 'h860, 8'h00, "R7 win1 protected read");
    idle("R7 final idle");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule